// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block chooses the three divider settings of a pixel clock synthesizer: an input divider M, a feedback multiplier N and a power-of-two output divider P. Software or a mode-setting sequencer gives it a requested pixel frequency, the reference frequency, the VCO operating window and the highest pixel clock the current mode may use. All of these are integer kHz values. The block captures them on a start pulse. It then brings the request inside the allowed range and works through every legal (P, M) pair in a fixed order. For each pair it derives a rounded N, computes the frequency that setting produces, and keeps the pair with the smallest error.

At the end of the scan the block presents a packed control word that can be written straight into the synthesizer's divider register, together with the frequency that word produces. It also shows whether any setting was legal at all. Both divisions in the scan, the N rounding and the achieved frequency, share one restoring divider that produces one quotient bit per cycle. A search therefore takes a few hundred to a few thousand cycles, depending on how many candidates pass the pruning checks.

Top module: `pix_div_search`

## Requirements
- R1: When start is seen while idle, the block captures all frequency inputs. The working request is then clamped in two steps. If the request is below floor(vco_min/16), it is raised to that value. After that, if it is above pclk_max, it is lowered to pclk_max.
- R2: P is tried as 1, 2, 4, 8, 16 in that order. A P value is skipped unless vco_min <= request×P <= vco_max.
- R3: For each P that is kept, M is tried from 7 up to 14. An M is skipped unless 1000×M <= ref <= 2000×M. This keeps the phase comparator between 1 and 2 MHz inclusive.
- R4: N = floor((2×request×P×M + ref) / (2×ref)), which is the VCO target times M over ref, rounded half up. A candidate is dropped unless 1 <= N <= 255.
- R5: The achieved frequency of a candidate is floor(ref×N / (M×P)), and its error is the absolute difference between this value and the clamped request. A candidate replaces the stored best only if its error is strictly smaller, so on a tie the earliest candidate in scan order is kept.
- R6: The control word is 32 bits. Bits 18:16 hold log2(P), from 0 to 4. Bits 15:8 hold N. Bits 7:0 hold M. All other bits are zero. achieved_khz reports the achieved frequency of the chosen setting.
- R7: busy goes high in the cycle after an accepted start, and done goes low at the same time. When the scan completes, busy falls and done rises together. done then stays high until the next accepted start. The result outputs change only when done rises.
- R8: A start pulse while busy is ignored: the running search finishes with the inputs it captured.
- R9: If no candidate passes, no_solution is 1, and both ctrl_word and achieved_khz are 0. Otherwise no_solution is 0.
- R10: After reset, busy, done and no_solution are 0, and ctrl_word and achieved_khz are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when idle |
| req_khz | input | FW | Requested pixel frequency, kHz |
| ref_khz | input | FW | Reference frequency, kHz |
| vco_min_khz | input | FW | Lowest VCO frequency, kHz |
| vco_max_khz | input | FW | Highest VCO frequency, kHz |
| pclk_max_khz | input | FW | Highest allowed pixel frequency, kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid, held until next start |
| no_solution | output | 1 | No legal setting was found |
| ctrl_word | output | 32 | Packed {log2 P, N, M} divider word |
| achieved_khz | output | FW | Frequency produced by ctrl_word, kHz |

## Verification
Some properties are checked by assertions on every cycle:
- The scan indices stay inside their ranges.
- Every N that reaches the frequency division lies between 1 and 255.
- busy and done are never high together.
- A finished result always has legal fields, or an all-zero word when no_solution is set.

Other behaviour can only be shown by the bench's scenarios, which compare against an independent model of the search: the clamping of the request, the rounding of N, the truncated achieved frequency, the earliest-wins tie rule, and the packing of the chosen setting. The bench scenarios also cover that a start pulse is ignored while busy and that results hold steady during a new search.

// File: rtl/pix_div_search.sv
module pix_div_search #(
  parameter int FW      = 20,
  parameter int PD_MIN  = 1000,
  parameter int PD_MAX  = 2000,
  parameter int M_FIRST = 7,
  parameter int M_LAST  = 14,
  parameter int P_LAST  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] req_khz,
  input  logic [FW-1:0] ref_khz,
  input  logic [FW-1:0] vco_min_khz,
  input  logic [FW-1:0] vco_max_khz,
  input  logic [FW-1:0] pclk_max_khz,
  output logic          busy,
  output logic          done,
  output logic          no_solution,
  output logic [31:0]   ctrl_word,
  output logic [FW-1:0] achieved_khz
);
  localparam int DW = FW + 8;
  localparam int VW = FW + 5;
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_PCHK, S_MCHK, S_NDIV, S_FDIV, S_NEXTM, S_FIN} st_t;
  st_t st;

  logic [FW-1:0] req_r, ref_r, vmin_r, vmax_r;
  logic [2:0]    p_log;
  logic [3:0]    m_r;
  logic [7:0]    n_r;
  logic [DW:0]   rem;
  logic [DW-1:0] quot, den;
  logic [CW-1:0] cnt;
  logic          best_ok;
  logic [DW-1:0] best_err;
  logic [FW-1:0] best_ach;
  logic [2:0]    best_p;
  logic [7:0]    best_n;
  logic [3:0]    best_m;

  logic [FW-1:0] lo_c, clamp1_c, clamp_c;
  assign lo_c     = vco_min_khz >> 4;
  assign clamp1_c = (req_khz < lo_c) ? lo_c : req_khz;
  assign clamp_c  = (clamp1_c > pclk_max_khz) ? pclk_max_khz : clamp1_c;

  logic [VW-1:0] fvco_c;
  assign fvco_c = VW'(req_r) << p_log;

  logic vco_ok_c, pd_ok_c;
  assign vco_ok_c = (fvco_c >= VW'(vmin_r)) && (fvco_c <= VW'(vmax_r));
  assign pd_ok_c  = (VW'(ref_r) >= VW'(m_r) * VW'(PD_MIN)) &&
                    (VW'(ref_r) <= VW'(m_r) * VW'(PD_MAX));

  logic [DW-1:0] num_n_c, den_n_c, num_f_c, den_f_c;
  assign num_n_c = DW'(fvco_c) * DW'(m_r) * DW'(2) + DW'(ref_r);
  assign den_n_c = DW'(ref_r) << 1;
  assign num_f_c = DW'(ref_r) * DW'(quot[7:0]);
  assign den_f_c = DW'(m_r) << p_log;

  logic [DW:0] trial_c;
  logic        sub_c;
  assign trial_c = {rem[DW-1:0], quot[DW-1]};
  assign sub_c   = trial_c >= {1'b0, den};

  logic          div_fin_c;
  logic [DW-1:0] err_c;
  assign div_fin_c = (cnt == '0);
  assign err_c = (quot > DW'(req_r)) ? quot - DW'(req_r) : DW'(req_r) - quot;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      req_r <= '0; ref_r <= '0; vmin_r <= '0; vmax_r <= '0;
      p_log <= '0; m_r <= '0; n_r <= '0;
      rem <= '0; quot <= '0; den <= '0; cnt <= '0;
      best_ok <= 1'b0; best_err <= '0; best_ach <= '0;
      best_p <= '0; best_n <= '0; best_m <= '0;
      done <= 1'b0; no_solution <= 1'b0; ctrl_word <= '0; achieved_khz <= '0;
    end else begin
      if ((st == S_NDIV || st == S_FDIV) && !div_fin_c) begin
        rem  <= sub_c ? trial_c - {1'b0, den} : trial_c;
        quot <= {quot[DW-2:0], sub_c};
        cnt  <= cnt - 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          req_r <= clamp_c; ref_r <= ref_khz;
          vmin_r <= vco_min_khz; vmax_r <= vco_max_khz;
          p_log <= '0; best_ok <= 1'b0; done <= 1'b0;
          st <= S_PCHK;
        end
        S_PCHK: begin
          if (vco_ok_c) begin
            m_r <= 4'(M_FIRST);
            st <= S_MCHK;
          end else if (p_log == 3'(P_LAST)) st <= S_FIN;
          else p_log <= p_log + 1'b1;
        end
        S_MCHK: begin
          if (pd_ok_c) begin
            rem <= '0; quot <= num_n_c; den <= den_n_c; cnt <= CW'(DW);
            st <= S_NDIV;
          end else st <= S_NEXTM;
        end
        S_NDIV: if (div_fin_c) begin
          if (quot >= DW'(1) && quot <= DW'(255)) begin
            n_r <= quot[7:0];
            rem <= '0; quot <= num_f_c; den <= den_f_c; cnt <= CW'(DW);
            st <= S_FDIV;
          end else st <= S_NEXTM;
        end
        S_FDIV: if (div_fin_c) begin
          if (!best_ok || err_c < best_err) begin
            best_ok <= 1'b1; best_err <= err_c; best_ach <= quot[FW-1:0];
            best_p <= p_log; best_n <= n_r; best_m <= m_r;
          end
          st <= S_NEXTM;
        end
        S_NEXTM: begin
          if (m_r == 4'(M_LAST)) begin
            if (p_log == 3'(P_LAST)) st <= S_FIN;
            else begin
              p_log <= p_log + 1'b1;
              st <= S_PCHK;
            end
          end else begin
            m_r <= m_r + 1'b1;
            st <= S_MCHK;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          no_solution <= !best_ok;
          ctrl_word <= best_ok ? {13'b0, best_p, best_n, 4'b0, best_m} : 32'b0;
          achieved_khz <= best_ok ? best_ach : '0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_p_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> p_log <= 3'(P_LAST));
  assert_m_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MCHK) |-> (m_r >= 4'(M_FIRST) && m_r <= 4'(M_LAST)));
  assert_n_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FDIV) |-> (n_r != 8'd0));
  assert_busy_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_solution) |-> (ctrl_word[18:16] <= 3'(P_LAST) &&
      ctrl_word[7:0] >= 8'(M_FIRST) && ctrl_word[7:0] <= 8'(M_LAST) &&
      ctrl_word[15:8] != 8'd0 && ctrl_word[31:19] == '0));
  assert_nosol_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_solution) |-> (ctrl_word == 32'b0 && achieved_khz == '0));
endmodule

// File: tb/pix_div_search_tb.sv
module pix_div_search_tb_top;
  localparam int FW = 20;
  logic clk = 0, rst_n = 0, start = 0;
  logic [FW-1:0] req, refk, vmin, vmax, pmax;
  logic busy, done, no_solution;
  logic [31:0] ctrl_word;
  logic [FW-1:0] achieved_khz;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  pix_div_search #(.FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_khz(req), .ref_khz(refk),
    .vco_min_khz(vmin), .vco_max_khz(vmax), .pclk_max_khz(pmax),
    .busy(busy), .done(done), .no_solution(no_solution),
    .ctrl_word(ctrl_word), .achieved_khz(achieved_khz));

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      fails++;
      $display("FAIL watchdog R7 act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input longint rq, rf, vn, vx, pm,
                                output longint w, output longint ach, output bit nos);
    longint r, lo, f, n, a, e, be;
    bit found;
    lo = vn / 16; r = rq;
    if (r < lo) r = lo;
    if (r > pm) r = pm;
    found = 0; be = 0; w = 0; ach = 0;
    for (int p = 0; p <= 4; p++) begin
      f = r * (1 << p);
      if (f >= vn && f <= vx)
        for (int m = 7; m <= 14; m++)
          if (rf >= 1000 * m && rf <= 2000 * m) begin
            n = (2 * f * m + rf) / (2 * rf);
            if (n >= 1 && n <= 255) begin
              a = (rf * n) / (m * (1 << p));
              e = (a > r) ? a - r : r - a;
              if (!found || e < be) begin
                found = 1; be = e; ach = a;
                w = (longint'(p) << 16) | (n << 8) | m;
              end
            end
          end
    end
    nos = !found;
  endfunction

  longint ew, ea;
  bit en;

  task automatic run(input longint rq, rf, vn, vx, pm, input string tag);
    req = FW'(rq); refk = FW'(rf); vmin = FW'(vn); vmax = FW'(vx); pmax = FW'(pm);
    model(rq, rf, vn, vx, pm, ew, ea, en);
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk({tag, " R6 word"}, ctrl_word, ew);
    chk({tag, " R5 achieved"}, achieved_khz, ea);
    chk({tag, " R9 no_solution"}, no_solution, en);
  endtask

  initial begin
    longint pw;
    req = 0; refk = 0; vmin = 0; vmax = 0; pmax = 0;
    repeat (3) @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 word", ctrl_word, 0);
    chk("R10 achieved", achieved_khz, 0);
    chk("R10 no_solution", no_solution, 0);
    rst_n = 1;
    @(negedge clk);

    run(25175, 27000, 150000, 350000, 400000, "basic R2 R3 R4");
    run(1, 14318, 160000, 350000, 400000, "clamp low R1");
    run(390000, 14318, 160000, 700000, 300000, "clamp high R1");
    run(60000, 5000, 150000, 350000, 400000, "pd window R3 R9");
    run(60000, 27000, 900000, 950000, 400000, "vco window R2 R9");
    run(100000, 14000, 100000, 1000000, 400000, "tie order R5");

    pw = ctrl_word;
    req = 40000; refk = 13500; vmin = 150000; vmax = 400000; pmax = 400000;
    model(40000, 13500, 150000, 400000, 400000, ew, ea, en);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R7 busy after start", busy, 1);
    chk("R7 done low", done, 0);
    chk("R7 word held", ctrl_word, pw);
    req = 200000; refk = 20000; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk("R8 word", ctrl_word, ew);
    chk("R8 achieved", achieved_khz, ea);
    repeat (3) @(negedge clk);
    chk("R7 done held", done, 1);

    void'($urandom(1234));
    for (int i = 0; i < 30; i++) begin
      longint rq, rf, vn, vx, pm;
      rq = 1000 + $urandom_range(0, 399000);
      rf = 6000 + $urandom_range(0, 26000);
      vn = 80000 + $urandom_range(0, 220000);
      vx = vn + $urandom_range(0, 1000000 - vn);
      pm = 50000 + $urandom_range(0, 350000);
      run(rq, rf, vn, vx, pm, "random R1 R2 R3 R4 R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule